// File: doc/BRIEF.md
# MicroWire Serial EEPROM Master

This controller drives a three-wire serial EEPROM (serial clock, chip select, data toward the device, data from the device). It takes one request at a time on a valid/ready command port. The supported requests are word read, word write, byte write, write-enable and write-disable. For each request it builds a frame whose length depends on the opcode and on the address width, shifts the frame out MSB first, and returns the read word.

After every write frame the controller releases chip select and raises it again. It then checks the device's ready indication on the data-in line, giving the device two waiting windows. If the device is still busy after the second window, the write is reported as failed. On parts organized as 16-bit words, a byte write is done as a read of the containing word, a merge of the new byte, and a write of the word.

Address width, word organization, serial bit period and poll wait are parameters. The host is expected to issue write-enable before a run of writes and write-disable after it.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, and after a reset asserted in the middle of a transfer, chip select and serial clock are low, `cmd_ready` is high, and `done` and `err` are low.
- R2: Each request uses one chip-select frame, except a byte write in word mode, which uses two. The frame holds 3+ADDR_W clock pulses for enable and disable, 3+ADDR_W+DW for a write, and 3+ADDR_W+1+DW for a read, where DW is 16 in word mode and 8 in byte mode.
- R3: Frames are sent MSB first and each starts with three bits: read 110, write 101, enable/disable 100. For read and write, the next field is the word address, which is the byte address shifted right by one in word mode. For a write, the data word follows the address. Enable sends address bits 11 followed by zeros, and disable sends all-zero address bits. Op codes on `cmd_op`: 0 read, 1 word write, 2 byte write, 3 enable, 4 disable.
- R4: The serial clock idles low and is high only while chip select is high. The data output changes only while the clock is low, and the data input is sampled when the clock rises.
- R5: On a read, the first bit returned after the address is discarded. The next DW bits, MSB first, appear on `rd_data` when `done` pulses.
- R6: After a write frame, chip select goes low for CLK_DIV cycles and then high. Data-in is sampled POLL_WAIT cycles later; if it is high, the request completes without error. If it is low, it is sampled once more after another POLL_WAIT cycles.
- R7: If data-in is low at both poll samples, `done` and `err` pulse together and chip select is released.
- R8: In word mode, a byte write to an odd byte address replaces bits 15:8 of the containing word with `cmd_wdata[7:0]`. A byte write to an even address replaces bits 7:0. The other byte is kept.
- R9: `cmd_ready` is high only when idle. A request is taken when valid and ready are both high. `done` is a one-cycle pulse. Op codes 5 to 7 start no frame and return `done` with `err` at once.
- R10: Each high phase and each low phase of the serial clock inside a frame lasts exactly CLK_DIV cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Controller idle, request taken |
| cmd_op | input | 3 | Request code |
| cmd_addr | input | ADDR_W+WORD16 | Byte address |
| cmd_wdata | input | DW | Write word, or byte in bits 7:0 |
| rd_data | output | DW | Last word read |
| done | output | 1 | Request finished (pulse) |
| err | output | 1 | Request failed (pulse with done) |
| mw_sck | output | 1 | Serial clock |
| mw_cs | output | 1 | Chip select, active high |
| mw_mosi | output | 1 | Data to device |
| mw_miso | input | 1 | Data and ready from device |

## Verification
A behavioural device model answers reads, stores writes only while enabled, and holds data-in low for a programmable busy time after a write. A table of requests runs the whole opcode set against low and high addresses, including the top word. It checks the exact bit pattern and pulse count of every frame, so opcode, address shift and data placement errors are told apart. Byte writes to odd and even addresses are each followed by a read-back, so a swapped merge shows up. A write made while disabled is read back to confirm it is left unchanged. Three busy times separate the first-sample, second-sample and timeout outcomes of the poll.

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int WORD16    = 1,
  parameter int CLK_DIV   = 2,
  parameter int POLL_WAIT = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [ADDR_W+WORD16-1:0] cmd_addr,
  input  logic [7+8*WORD16:0]      cmd_wdata,
  output logic [7+8*WORD16:0]      rd_data,
  output logic                     done,
  output logic                     err,
  output logic                     mw_sck,
  output logic                     mw_cs,
  output logic                     mw_mosi,
  input  logic                     mw_miso
);
  localparam int DW   = 8 + 8*WORD16;
  localparam int BA_W = ADDR_W + WORD16;
  localparam int HD_W = 3 + ADDR_W;
  localparam int TX_W = HD_W + DW + 1;
  localparam int BC_W = $clog2(TX_W + 1);
  localparam int DC_W = $clog2(CLK_DIV + 1);
  localparam int PC_W = $clog2(POLL_WAIT + 1);

  localparam logic [2:0] OP_RD  = 3'd0;
  localparam logic [2:0] OP_WR  = 3'd1;
  localparam logic [2:0] OP_WB  = 3'd2;
  localparam logic [2:0] OP_EN  = 3'd3;
  localparam logic [2:0] OP_DIS = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_GAP, S_POLL} st_t;

  st_t              st;
  logic [2:0]       op_q;
  logic [BA_W-1:0]  addr_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rx_sr;
  logic [TX_W-1:0]  tx_sr;
  logic [BC_W-1:0]  flen, bcnt;
  logic [DC_W-1:0]  dcnt;
  logic [PC_W-1:0]  pcnt;
  logic             retry, rmw_rd;

  logic [ADDR_W-1:0] waddr, f_addr;
  logic [2:0]        f_op;
  logic [DW-1:0]     f_dat, merged;
  logic [BC_W-1:0]   f_len;
  logic              is_wr, phase_end, poll_end;

  assign waddr     = addr_q[BA_W-1 -: ADDR_W];
  assign is_wr     = (op_q == OP_WR) || (op_q == OP_WB);
  assign cmd_ready = (st == S_IDLE);
  assign mw_mosi   = mw_cs & tx_sr[TX_W-1];
  assign phase_end = (dcnt == DC_W'(CLK_DIV - 1));
  assign poll_end  = (pcnt == PC_W'(POLL_WAIT - 1));

  generate
    if (WORD16 != 0) begin : g_merge16
      assign merged = addr_q[0] ? {wdata_q[7:0], rx_sr[7:0]}
                                : {rx_sr[DW-1:8], wdata_q[7:0]};
    end else begin : g_merge8
      assign merged = wdata_q;
    end
  endgenerate

  always_comb begin
    f_op   = 3'b110;
    f_addr = waddr;
    f_dat  = '0;
    f_len  = BC_W'(HD_W + 1 + DW);
    if (!rmw_rd) begin
      case (op_q)
        OP_WR, OP_WB: begin
          f_op  = 3'b101;
          f_dat = wdata_q;
          f_len = BC_W'(HD_W + DW);
        end
        OP_EN: begin
          f_op   = 3'b100;
          f_addr = {2'b11, {(ADDR_W-2){1'b0}}};
          f_len  = BC_W'(HD_W);
        end
        OP_DIS: begin
          f_op   = 3'b100;
          f_addr = '0;
          f_len  = BC_W'(HD_W);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      flen    <= '0;
      bcnt    <= '0;
      dcnt    <= '0;
      pcnt    <= '0;
      retry   <= 1'b0;
      rmw_rd  <= 1'b0;
      rd_data <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      mw_sck  <= 1'b0;
      mw_cs   <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            if (cmd_op > OP_DIS) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else begin
              op_q    <= cmd_op;
              addr_q  <= cmd_addr;
              wdata_q <= cmd_wdata;
              rmw_rd  <= (cmd_op == OP_WB) && (WORD16 != 0);
              st      <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          tx_sr <= {f_op, f_addr, f_dat, 1'b0};
          flen  <= f_len;
          bcnt  <= '0;
          dcnt  <= '0;
          mw_cs <= 1'b1;
          st    <= S_XFER;
        end
        S_XFER: begin
          if (phase_end) begin
            dcnt <= '0;
            if (!mw_sck) begin
              mw_sck <= 1'b1;
              rx_sr  <= {rx_sr[DW-2:0], mw_miso};
            end else begin
              mw_sck <= 1'b0;
              tx_sr  <= tx_sr << 1;
              if (bcnt == flen - 1'b1) begin
                mw_cs <= 1'b0;
                st    <= S_GAP;
              end else begin
                bcnt <= bcnt + 1'b1;
              end
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_GAP: begin
          if (phase_end) begin
            dcnt <= '0;
            if (rmw_rd) begin
              wdata_q <= merged;
              rmw_rd  <= 1'b0;
              st      <= S_LOAD;
            end else if (is_wr) begin
              mw_cs <= 1'b1;
              pcnt  <= '0;
              retry <= 1'b0;
              st    <= S_POLL;
            end else begin
              if (op_q == OP_RD) rd_data <= rx_sr;
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        S_POLL: begin
          if (poll_end) begin
            pcnt <= '0;
            if (mw_miso) begin
              mw_cs <= 1'b0;
              done  <= 1'b1;
              st    <= S_IDLE;
            end else if (!retry) begin
              retry <= 1'b1;
            end else begin
              mw_cs <= 1'b0;
              done  <= 1'b1;
              err   <= 1'b1;
              st    <= S_IDLE;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic done,
  input logic err,
  input logic mw_sck,
  input logic mw_cs,
  input logic mw_mosi
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= mw_sck ? hi_run + 1'b1 : '0;
  end

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sck |-> mw_cs);  // R4
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sck && $past(mw_sck)) |-> $stable(mw_mosi));  // R4
  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_sck) |-> (hi_run == 16'(CLK_DIV)));  // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mw_cs |-> !cmd_ready);  // R9
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);  // R7
  AST_CS_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mw_cs);  // R6
endmodule

bind mw_eeprom_ctrl mw_eeprom_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done(done), .err(err),
  .mw_sck(mw_sck), .mw_cs(mw_cs), .mw_mosi(mw_mosi)
);

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, WORD16 = 1, CLK_DIV = 2, POLL_WAIT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [8:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0, rd_data;
  logic done, err, mw_sck, mw_cs, mw_mosi, mw_miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_ctrl #(.ADDR_W(ADDR_W), .WORD16(WORD16), .CLK_DIV(CLK_DIV), .POLL_WAIT(POLL_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rd_data(rd_data),
    .done(done), .err(err), .mw_sck(mw_sck), .mw_cs(mw_cs), .mw_mosi(mw_mosi), .mw_miso(mw_miso));

  // device model
  logic [15:0] mem [256];
  logic p_sck, p_cs, rd_on, wen, rbit, wr_pend;
  logic [31:0] sr;
  logic [2:0] opq;
  logic [7:0] raddr, waddr;
  int cnt, k, busy, busy_len;

  assign mw_miso = mw_cs ? ((cnt == 0) ? (busy == 0) : rbit) : 1'b0;

  always @(posedge clk) begin
    logic [31:0] nsr;
    int n;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], ~i[7:0]};
      p_sck <= 0; p_cs <= 0; rd_on <= 0; wen <= 0; rbit <= 0; wr_pend <= 0;
      sr <= 0; opq <= 0; raddr <= 0; waddr <= 0; cnt <= 0; k <= 0; busy <= 0;
    end else begin
      p_sck <= mw_sck;
      p_cs  <= mw_cs;
      if (mw_cs && !p_cs) begin cnt <= 0; rd_on <= 0; end
      if (!mw_cs && p_cs && wr_pend) begin busy <= busy_len; wr_pend <= 0; end
      else if (busy > 0) busy <= busy - 1;
      if (mw_cs && mw_sck && !p_sck) begin
        nsr = {sr[30:0], mw_mosi};
        n = cnt + 1;
        sr <= nsr;
        cnt <= n;
        if (n == 11) begin
          opq <= nsr[10:8];
          case (nsr[10:8])
            3'b110: begin rd_on <= 1; k <= 0; raddr <= nsr[7:0]; end
            3'b101: waddr <= nsr[7:0];
            3'b100: begin
              if (nsr[7:6] == 2'b11) wen <= 1;
              else if (nsr[7:6] == 2'b00) wen <= 0;
            end
            default: ;
          endcase
        end
        if (n == 27 && opq == 3'b101 && wen) begin
          mem[waddr] <= nsr[15:0];
          wr_pend <= 1;
        end
      end
      if (mw_cs && !mw_sck && p_sck && rd_on) begin
        if (k == 0) rbit <= 0;
        else if (k <= 16) rbit <= mem[raddr][16-k];
        k <= k + 1;
      end
    end
  end

  // port monitor
  logic m_sck = 0, m_cs = 0, m_mosi = 0;
  logic [63:0] cur_v = 0, last_v = 0;
  int cur_n = 0, last_n = 0, nframes = 0, hi = 0, lo = 0;
  int hi_bad = 0, lo_bad = 0, mosi_bad = 0, sck_nocs = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mw_cs && !m_cs) begin cur_n = 0; cur_v = 0; end
      if (mw_cs && mw_sck && !m_sck) begin cur_v = {cur_v[62:0], mw_mosi}; cur_n++; end
      if (!mw_cs && m_cs && cur_n > 0) begin last_n = cur_n; last_v = cur_v; nframes++; end
      if (mw_sck) hi++;
      else if (m_sck) begin if (hi != CLK_DIV) hi_bad++; hi = 0; end
      if (!mw_cs) lo = 0;
      else if (!mw_sck) lo++;
      else if (!m_sck) begin if (lo != CLK_DIV) lo_bad++; lo = 0; end
      if (mw_sck && m_sck && mw_mosi != m_mosi) mosi_bad++;
      if (mw_sck && !mw_cs) sck_nocs++;
    end
    m_sck = mw_sck; m_cs = mw_cs; m_mosi = mw_mosi;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [8:0] a, input logic [15:0] d,
                         output logic g_err, output logic [15:0] g_rd, output int frames);
    int f0, t;
    f0 = nframes;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (op <= 3'd4) chk(!cmd_ready, "R9 ready after accept", cmd_ready, 0);
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, "R9 done seen", t, 0);
    g_err = err; g_rd = rd_data;
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    frames = nframes - f0;
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [8:0]  addr;
    logic [15:0] wd;
    logic        chk_rd;
    logic [15:0] rd;
    logic [5:0]  nb;
    logic [31:0] fr;
    logic [1:0]  nf;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{3'd3, 9'h000, 16'h0000, 1'b0, 16'h0000, 6'd11, 32'h0000_04C0, 2'd1},
    '{3'd1, 9'h020, 16'hA5C3, 1'b0, 16'h0000, 6'd27, 32'h0510_A5C3, 2'd1},
    '{3'd0, 9'h020, 16'h0000, 1'b1, 16'hA5C3, 6'd28, 32'h0C20_0000, 2'd1},
    '{3'd2, 9'h021, 16'h007E, 1'b0, 16'h0000, 6'd27, 32'h0510_7EC3, 2'd2},
    '{3'd0, 9'h021, 16'h0000, 1'b1, 16'h7EC3, 6'd28, 32'h0C20_0000, 2'd1},
    '{3'd2, 9'h020, 16'h0011, 1'b0, 16'h0000, 6'd27, 32'h0510_7E11, 2'd2},
    '{3'd0, 9'h020, 16'h0000, 1'b1, 16'h7E11, 6'd28, 32'h0C20_0000, 2'd1},
    '{3'd4, 9'h000, 16'h0000, 1'b0, 16'h0000, 6'd11, 32'h0000_0400, 2'd1},
    '{3'd1, 9'h030, 16'hFFFF, 1'b0, 16'h0000, 6'd27, 32'h0518_FFFF, 2'd1},
    '{3'd0, 9'h030, 16'h0000, 1'b1, 16'h18E7, 6'd28, 32'h0C30_0000, 2'd1},
    '{3'd0, 9'h1FF, 16'h0000, 1'b1, 16'hFF00, 6'd28, 32'h0DFE_0000, 2'd1},
    '{3'd3, 9'h000, 16'h0000, 1'b0, 16'h0000, 6'd11, 32'h0000_04C0, 2'd1},
    '{3'd1, 9'h1FE, 16'h1234, 1'b0, 16'h0000, 6'd27, 32'h05FF_1234, 2'd1},
    '{3'd0, 9'h1FF, 16'h0000, 1'b1, 16'h1234, 6'd28, 32'h0DFE_0000, 2'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic e;
    logic [15:0] r;
    int f;
    vec_t v;
    busy_len = 30;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(!mw_cs && !mw_sck, "R1 lines idle", {mw_cs, mw_sck}, 0);
    chk(cmd_ready && !done && !err, "R1 handshake idle", {cmd_ready, done, err}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      v = VEC[i];
      run_cmd(v.op, v.addr, v.wd, e, r, f);
      chk(last_n == int'(v.nb), "R2 frame length", last_n, v.nb);
      chk(last_v == {32'h0, v.fr}, "R3 frame bits", last_v, v.fr);
      chk(f == int'(v.nf), (v.op == 3'd2) ? "R8 frame count" : "R2 frame count", f, v.nf);
      chk(!e, "R6 no error", e, 0);
      if (v.chk_rd)
        chk(r == v.rd, (i == 4 || i == 6) ? "R8 merged word" : "R5 read data", r, v.rd);
    end

    // R6 ready at first poll sample
    busy_len = 3;
    run_cmd(3'd1, 9'h040, 16'hBEEF, e, r, f);
    chk(!e, "R6 first sample ready", e, 0);
    run_cmd(3'd0, 9'h040, 16'h0, e, r, f);
    chk(r == 16'hBEEF, "R6 write stored", r, 16'hBEEF);

    // R7 timeout
    busy_len = 200;
    run_cmd(3'd1, 9'h042, 16'h5555, e, r, f);
    chk(e, "R7 timeout error", e, 1);
    chk(!mw_cs, "R7 cs released", mw_cs, 0);
    repeat (250) @(negedge clk);

    // R9 reserved code
    run_cmd(3'd7, 9'h000, 16'h0, e, r, f);
    chk(e, "R9 reserved code error", e, 1);
    chk(f == 0, "R9 reserved code no frame", f, 0);

    chk(hi_bad == 0, "R10 high phase", hi_bad, 0);
    chk(lo_bad == 0, "R10 low phase", lo_bad, 0);
    chk(mosi_bad == 0, "R4 data held while clock high", mosi_bad, 0);
    chk(sck_nocs == 0, "R4 clock only inside frame", sck_nocs, 0);

    // R1 reset in the middle of a frame
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd0; cmd_addr = 9'h010;
    @(negedge clk);
    cmd_valid = 0;
    repeat (30) @(negedge clk);
    chk(mw_cs, "R1 frame in progress", mw_cs, 1);
    rst_n = 0;
    @(negedge clk);
    chk(!mw_cs && !mw_sck, "R1 lines idle after reset", {mw_cs, mw_sck}, 0);
    chk(cmd_ready && !done && !err, "R1 handshake after reset", {cmd_ready, done, err}, 3'b100);

    summary();
    $finish;
  end
endmodule